// File: doc/BRIEF.md
# Carry-Save Add/Subtract 4:2 Compressor

This block adds or subtracts two operands that are both held in redundant carry-save form. Each operand is a pair of N-bit words, and the value it stands for is the sum of the two words. The result comes back in the same two-word form. Two rows of full adders reduce the four incoming words to two. Because no carry travels along the word, the logic depth does not depend on the width. A 2:1 multiplexer on the second operand selects either its two words unchanged or their bitwise inverses. In subtract mode, the select bit also enters as the carry-in at bit 0 of both adder rows. Those two injected ones turn the two one's-complement words into a true negation of the second operand.

A build parameter removes the multiplexer and the select path, which leaves a plain adder. A second parameter places an output register stage that carries a valid flag, so the latency is exactly one cycle. All arithmetic wraps modulo 2^N. Resolving the result to binary is left to the consumer, for example a final carry-propagate adder.

Top module: `csa_addsub42`

## Requirements
- R1: With `op_sub`=0, (`res_carry` + `res_save`) mod 2^N equals (`a_carry` + `a_save` + `b_carry` + `b_save`) mod 2^N.
- R2: With `op_sub`=1, (`res_carry` + `res_save`) mod 2^N equals (`a_carry` + `a_save` − `b_carry` − `b_save`) mod 2^N.
- R3: Bit 0 of `res_carry` equals the `op_sub` value of the same operation, because the select bit is the carry-in of the second row.
- R4: With the register stage enabled (default), a result appears on the outputs one clock edge after its operands are sampled, and it is held until the next edge.
- R5: `res_valid` equals the `in_valid` value sampled at the previous clock edge.
- R6: A synchronous active-high `rst` clears `res_valid`, `res_carry` and `res_save` to zero at the next edge, whatever the inputs are.
- R7: Carries out of the most significant bit are discarded. For example, all-ones words added together wrap modulo 2^N.
- R8: Subtracting an operand from itself (A − A, with `op_sub`=1) gives a result whose two words sum to zero modulo 2^N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on the inputs are valid this cycle |
| op_sub | input | 1 | 0 = A + B, 1 = A − B (ignored when subtraction is not built) |
| a_carry | input | WIDTH | Carry word of operand A |
| a_save | input | WIDTH | Save word of operand A |
| b_carry | input | WIDTH | Carry word of operand B |
| b_save | input | WIDTH | Save word of operand B |
| res_valid | output | 1 | Result words are valid |
| res_carry | output | WIDTH | Carry word of the result |
| res_save | output | WIDTH | Save word of the result |

## Verification
The inversion of operand B and the injection of the two carry-ins can act in the same cycle as a wraparound at the top bit. The bench provokes this with subtract vectors that use all-ones or zero words. It then compares the wrapped sum of the two output words against a difference computed modulo 2^N. A result register that captures new data while a reset edge is also pending is another overlap. The bench provokes it by holding `in_valid` and the operands active during reset, and it expects zeros on the outputs.

// File: rtl/csa_pkg.sv
package csa_pkg;
  typedef enum logic {OP_ADD = 1'b0, OP_SUB = 1'b1} csa_op_e;
endpackage

// File: rtl/csa_fa_row.sv
module csa_fa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] cout
);
  localparam int WX = W + 2;

  for (genvar i = 0; i < W; i++) begin : g_col
    assign sum[i]  = x[i] ^ y[i] ^ z[i];
    assign cout[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end

  // Each column must conserve its weight: sum + 2*cout == x + y + z.
  always_comb begin
    if (!$isunknown({x, y, z})) begin
      assert_row_conserves_R1: assert ((WX'(x) + WX'(y) + WX'(z)) ==
                                       (WX'(sum) + (WX'(cout) << 1)));
    end
  end
endmodule

// File: rtl/csa_operand_sel.sv
module csa_operand_sel
  import csa_pkg::*;
#(
  parameter int W       = 16,
  parameter bit HAS_SUB = 1'b1
) (
  input  logic         sub_in,
  input  logic [W-1:0] bc_in,
  input  logic [W-1:0] bs_in,
  output logic         cin,
  output logic [W-1:0] bc_out,
  output logic [W-1:0] bs_out
);
  if (HAS_SUB) begin : g_sub
    csa_op_e op;
    assign op     = csa_op_e'(sub_in);
    assign cin    = (op == OP_SUB);
    assign bc_out = (op == OP_SUB) ? ~bc_in : bc_in;
    assign bs_out = (op == OP_SUB) ? ~bs_in : bs_in;
  end else begin : g_add_only
    logic unused_sub;
    assign unused_sub = sub_in;
    assign cin    = 1'b0;
    assign bc_out = bc_in;
    assign bs_out = bs_in;
  end
endmodule

// File: rtl/csa_out_stage.sv
module csa_out_stage #(
  parameter int W    = 16,
  parameter bit PIPE = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         d_valid,
  input  logic [W-1:0] d_carry,
  input  logic [W-1:0] d_save,
  output logic         q_valid,
  output logic [W-1:0] q_carry,
  output logic [W-1:0] q_save
);
  if (PIPE) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        q_valid <= 1'b0;
        q_carry <= '0;
        q_save  <= '0;
      end else begin
        q_valid <= d_valid;
        q_carry <= d_carry;
        q_save  <= d_save;
      end
    end

    assert_valid_rise_R5: assert property (@(posedge clk) disable iff (rst)
      d_valid |=> q_valid);
    assert_valid_low_R5: assert property (@(posedge clk) disable iff (rst)
      !d_valid |=> !q_valid);
    assert_reset_clears_R6: assert property (@(posedge clk)
      rst |=> (!q_valid && q_carry == '0 && q_save == '0));
    assert_hold_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (q_carry == $past(d_carry) && q_save == $past(d_save)));
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst;
    assign q_valid = d_valid;
    assign q_carry = d_carry;
    assign q_save  = d_save;
  end
endmodule

// File: rtl/csa_addsub42.sv
module csa_addsub42 #(
  parameter int WIDTH   = 16,
  parameter bit HAS_SUB = 1'b1,
  parameter bit PIPE    = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] a_carry,
  input  logic [WIDTH-1:0] a_save,
  input  logic [WIDTH-1:0] b_carry,
  input  logic [WIDTH-1:0] b_save,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_carry,
  output logic [WIDTH-1:0] res_save
);
  localparam int MSB = WIDTH - 1;

  logic             cin;
  logic [WIDTH-1:0] bc_sel, bs_sel;
  logic [WIDTH-1:0] s1, c1, c1_sh;
  logic [WIDTH-1:0] s2, c2, c2_sh;

  csa_operand_sel #(.W(WIDTH), .HAS_SUB(HAS_SUB)) sel_i (
    .sub_in(op_sub), .bc_in(b_carry), .bs_in(b_save),
    .cin(cin), .bc_out(bc_sel), .bs_out(bs_sel)
  );

  csa_fa_row #(.W(WIDTH)) row1_i (
    .x(a_save), .y(a_carry), .z(bs_sel), .sum(s1), .cout(c1)
  );

  assign c1_sh = {c1[MSB-1:0], cin};

  csa_fa_row #(.W(WIDTH)) row2_i (
    .x(s1), .y(c1_sh), .z(bc_sel), .sum(s2), .cout(c2)
  );

  assign c2_sh = {c2[MSB-1:0], cin};

  csa_out_stage #(.W(WIDTH), .PIPE(PIPE)) out_i (
    .clk(clk), .rst(rst), .d_valid(in_valid),
    .d_carry(c2_sh), .d_save(s2),
    .q_valid(res_valid), .q_carry(res_carry), .q_save(res_save)
  );

  if (HAS_SUB) begin : g_chk_sub
    assert_add_value_R1: assert property (@(posedge clk) disable iff (rst)
      !op_sub |-> (WIDTH'(c2_sh + s2) == WIDTH'(a_carry + a_save + b_carry + b_save)));
    assert_sub_value_R2: assert property (@(posedge clk) disable iff (rst)
      op_sub |-> (WIDTH'(c2_sh + s2) == WIDTH'(a_carry + a_save - b_carry - b_save)));
  end else begin : g_chk_add
    assert_add_value_R1: assert property (@(posedge clk) disable iff (rst)
      WIDTH'(c2_sh + s2) == WIDTH'(a_carry + a_save + b_carry + b_save));
  end
endmodule

// File: tb/csa_addsub42_tb_top.sv
module csa_addsub42_tb_top;
  localparam int W = 16;
  localparam int NTBL = 8;
  localparam int NRAND = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic op_sub = 1'b0;
  logic [W-1:0] a_carry = '0, a_save = '0, b_carry = '0, b_save = '0;
  logic res_valid;
  logic [W-1:0] res_carry, res_save;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  csa_addsub42 #(.WIDTH(W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sub(op_sub),
    .a_carry(a_carry), .a_save(a_save), .b_carry(b_carry), .b_save(b_save),
    .res_valid(res_valid), .res_carry(res_carry), .res_save(res_save)
  );

  // {sub, a_carry, a_save, b_carry, b_save}
  localparam logic [4*W:0] TBL [NTBL] = '{
    {1'b0, 16'h0001, 16'h0002, 16'h0003, 16'h0004},
    {1'b1, 16'h0010, 16'h0020, 16'h0003, 16'h0004},
    {1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF},
    {1'b1, 16'h1234, 16'h5678, 16'h1234, 16'h5678},
    {1'b0, 16'h8000, 16'h8000, 16'h0000, 16'h0001},
    {1'b1, 16'h0000, 16'h0001, 16'h0000, 16'h0002},
    {1'b0, 16'hA5A5, 16'h5A5A, 16'h0F0F, 16'hF0F0}
  };

  function automatic logic [W-1:0] ref_val(logic s, logic [W-1:0] ac, logic [W-1:0] as_,
                                           logic [W-1:0] bc, logic [W-1:0] bs);
    if (s) return ac + as_ - bc - bs;
    return ac + as_ + bc + bs;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check at the following negedge (one register stage)
  task automatic apply(logic v, logic s, logic [W-1:0] ac, logic [W-1:0] as_,
                       logic [W-1:0] bc, logic [W-1:0] bs);
    logic [W-1:0] exp;
    in_valid = v; op_sub = s; a_carry = ac; a_save = as_; b_carry = bc; b_save = bs;
    exp = ref_val(s, ac, as_, bc, bs);
    @(negedge clk);
    check(s ? "R2" : "R1", res_carry + res_save, exp);
    check("R3", W'(res_carry[0]), W'(s));
    check("R5", W'(res_valid), W'(v));
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R6: reset with active inputs
    in_valid = 1'b1; op_sub = 1'b1; a_carry = 16'h1111; b_save = 16'h2222;
    repeat (3) @(negedge clk);
    check("R6", W'(res_valid), '0);
    check("R6", res_carry, '0);
    check("R6", res_save, '0);
    rst = 1'b0;

    for (int i = 0; i < NTBL; i++) begin
      apply(1'b1, TBL[i][4*W], TBL[i][4*W-1:3*W], TBL[i][3*W-1:2*W],
            TBL[i][2*W-1:W], TBL[i][W-1:0]);
    end

    // R7: wraparound with all ones
    apply(1'b1, 1'b0, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF);
    check("R7", res_carry + res_save, 16'hFFFC);
    // R8: A - A
    apply(1'b1, 1'b1, 16'hBEEF, 16'h7531, 16'hBEEF, 16'h7531);
    check("R8", res_carry + res_save, '0);

    // R4: output holds for a cycle with no new operand; then tracks the next
    in_valid = 1'b0; op_sub = 1'b0;
    a_carry = 16'h0005; a_save = 16'h0006; b_carry = 16'h0007; b_save = 16'h0008;
    #1;
    check("R4", res_carry + res_save, '0);
    @(negedge clk);
    check("R4", res_carry + res_save, 16'h001A);
    check("R5", W'(res_valid), '0);

    for (int i = 0; i < NRAND; i++) begin
      apply(1'($urandom), 1'($urandom), W'($urandom), W'($urandom),
            W'($urandom), W'($urandom));
    end

    // R6: reset after traffic
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check("R6", W'(res_valid), '0);
    check("R6", res_carry | res_save, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule